// File: doc/BRIEF.md
# H-Bridge PWM/Direction Gate Sequencer

This block turns a PWM command and a direction command into four gate-enable signals for a full H-bridge. The bridge has two legs, A and B. Each leg has a high-side switch and a low-side switch. When PWM is low the bridge brakes, with both high sides conducting. When PWM is high the direction input picks which diagonal pair conducts. Fast-decay control comes from holding PWM high and putting the modulation on the direction input. All inputs are synchronous to `clk`, and every time interval is a count of `clk` cycles.

Each leg is sequenced by its own state machine. The states are:

- `LEG_IDLE`: both switches off. This is the state after reset or disable.
- `LEG_GAP_HI` and `LEG_GAP_LO`: both switches off while the dead-time counter runs toward the named side.
- `LEG_DRV_HI` and `LEG_DRV_LO`: the named switch conducts.

The transitions are:

- `IDLE→GAP_x`: the leg is enabled and starts toward the commanded side x.
- `DRV_x→GAP_y`: the command has changed to the other side y.
- `GAP_x→GAP_y`: the command flipped during the gap, so the counter restarts.
- `GAP_x→DRV_x`: the counter has expired.
- `DRV_x→DRV_y` and `GAP_x→DRV_y`: these happen only in bypass mode.
- `any→IDLE`: the global disable is asserted.

A per-switch fault mask from a protection block and a global disable both force gates off in the same cycle, without going through the sequencing.

Top module: `hbridge_gate_seq`

## Requirements
- R1: While reset is low, all four gate enables are 0. After reset is released with bypass off, all gates stay 0 for max(D,1) cycles, where D is `dead_cycles`. Only then does the commanded side of each leg turn on.
- R2: The steady-state gate pattern follows the command. The bits of `gate_en` are [0]=A high, [1]=A low, [2]=B high, [3]=B low.
  - PWM=0 gives 0101 (both high sides on, braking).
  - PWM=1 with DIR=1 gives 1001.
  - PWM=1 with DIR=0 gives 0110.
- R3: The high and low enables of the same leg are never 1 in the same cycle.
- R4: With bypass off, a change in a leg's commanded side turns off the conducting switch of that leg on the next clock edge. Both switches of that leg then stay off for max(D,1) cycles before the new side turns on.
- R5: A change of command while a leg is in its gap reloads the counter from D and aims it at the latest side. The full gap then starts over.
- R6: With `dt_bypass`=1, a leg switches to its newly commanded side on the next clock edge, with no all-off cycle.
- R7: `disable_all`=1 forces `gate_en` to 0 in the same cycle. After it is released, every leg goes through a full gap of max(D,1) cycles before any side turns on.
- R8: `fault_mask[i]`=1 forces `gate_en[i]` to 0 in the same cycle and leaves the other gates alone. The leg's sequencing continues unchanged, so the gates resume as soon as the mask clears.
- R9: In fast-decay use (PWM held at 1, DIR toggling), both legs enter their gaps on the same edge and each waits its own dead time.
- R10: D is captured when a gap starts. Changing `dead_cycles` during a gap does not change the length of that gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 1 | PWM command; 0 means brake on both high sides |
| dir_in | input | 1 | Direction command; 1 selects A high with B low |
| dt_bypass | input | 1 | 1 removes dead time; legs swap sides on the next edge |
| dead_cycles | input | DT_W | Dead time in clock cycles (0 and 1 both give one cycle) |
| disable_all | input | 1 | Forces all gates off immediately |
| fault_mask | input | 4 | Per-switch off-force, same bit order as gate_en |
| gate_en | output | 4 | Gate enables: [0] A high, [1] A low, [2] B high, [3] B low |

## Verification
The bench builds the block with `DT_W`=6. This keeps dead times between 0 and 63 cycles, so the following cases all fit in short runs:

- expiry at a count of 1;
- the 0-versus-1 corner;
- restarts partway through a gap;
- a mid-gap change of D to 20.

Random stimulus draws D from 0 to 7, so gaps often overlap with new command changes, disables and fault masks. A cycle-level reference model written from the requirements checks `gate_en` every cycle.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    localparam int LEGS = 2;
    localparam int GATES = 2 * LEGS;

    typedef enum logic [2:0] {
        LEG_IDLE   = 3'd0,
        LEG_GAP_HI = 3'd1,
        LEG_GAP_LO = 3'd2,
        LEG_DRV_HI = 3'd3,
        LEG_DRV_LO = 3'd4
    } leg_state_t;

endpackage

// File: rtl/hbg_cmd_map.sv
// Maps the bridge command onto a per-leg side request (1 = high side).
module hbg_cmd_map
    import hbg_pkg::*;
(
    input  logic            pwm_in,
    input  logic            dir_in,
    output logic [LEGS-1:0] want_hi
);

    always_comb begin
        // Braking (pwm low) requests both high sides.
        // Otherwise the direction picks the diagonal.
        want_hi[0] = !pwm_in || dir_in;
        want_hi[1] = !pwm_in || !dir_in;
    end

endmodule

// File: rtl/hbg_leg_fsm.sv
// One half-bridge sequencer with dead-time insertion.
module hbg_leg_fsm
    import hbg_pkg::*;
#(
    parameter int DT_W = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            want_hi,
    input  logic [DT_W-1:0] dead_cycles,
    input  logic            dt_bypass,
    input  logic            disable_all,
    output logic            hi_cmd,
    output logic            lo_cmd
);

    localparam logic [DT_W-1:0] CNT_ONE = DT_W'(1);

    leg_state_t      state_q, state_d;
    logic [DT_W-1:0] cnt_q;
    logic            load_cnt;
    leg_state_t      drv_want;
    leg_state_t      gap_want;

    always_comb begin
        drv_want = want_hi ? LEG_DRV_HI : LEG_DRV_LO;
        gap_want = want_hi ? LEG_GAP_HI : LEG_GAP_LO;
    end

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        load_cnt = 1'b0;
        unique case (state_q)
            LEG_IDLE: begin
                if (dt_bypass) begin
                    state_d = drv_want;
                end else begin
                    state_d  = gap_want;
                    load_cnt = 1'b1;
                end
            end
            LEG_GAP_HI: begin
                if (dt_bypass) begin
                    state_d = drv_want;
                end else if (!want_hi) begin
                    state_d  = LEG_GAP_LO;
                    load_cnt = 1'b1;
                end else if (cnt_q <= CNT_ONE) begin
                    state_d = LEG_DRV_HI;
                end
            end
            LEG_GAP_LO: begin
                if (dt_bypass) begin
                    state_d = drv_want;
                end else if (want_hi) begin
                    state_d  = LEG_GAP_HI;
                    load_cnt = 1'b1;
                end else if (cnt_q <= CNT_ONE) begin
                    state_d = LEG_DRV_LO;
                end
            end
            LEG_DRV_HI: begin
                if (!want_hi) begin
                    if (dt_bypass) begin
                        state_d = LEG_DRV_LO;
                    end else begin
                        state_d  = LEG_GAP_LO;
                        load_cnt = 1'b1;
                    end
                end
            end
            LEG_DRV_LO: begin
                if (want_hi) begin
                    if (dt_bypass) begin
                        state_d = LEG_DRV_HI;
                    end else begin
                        state_d  = LEG_GAP_HI;
                        load_cnt = 1'b1;
                    end
                end
            end
            default: begin
                state_d = LEG_IDLE;
            end
        endcase
        if (disable_all) begin
            state_d  = LEG_IDLE;
            load_cnt = 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LEG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Dead-time counter: loaded when a gap begins, counts down inside it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_cnt) begin
            cnt_q <= dead_cycles;
        end else if ((state_q == LEG_GAP_HI || state_q == LEG_GAP_LO) && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    // Output process
    always_comb begin
        hi_cmd = 1'b0;
        lo_cmd = 1'b0;
        unique case (state_q)
            LEG_DRV_HI: hi_cmd = 1'b1;
            LEG_DRV_LO: lo_cmd = 1'b1;
            default: begin
                hi_cmd = 1'b0;
                lo_cmd = 1'b0;
            end
        endcase
    end

    AST_SWAP_NEEDS_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(state_q) == LEG_DRV_LO) && (state_q == LEG_DRV_HI)) ||
         (($past(state_q) == LEG_DRV_HI) && (state_q == LEG_DRV_LO))) |-> $past(dt_bypass)); // R6

    AST_GAP_EXIT_AT_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(state_q) == LEG_GAP_HI) && (state_q == LEG_DRV_HI)) ||
         (($past(state_q) == LEG_GAP_LO) && (state_q == LEG_DRV_LO))) && !$past(dt_bypass)
        |-> ($past(cnt_q) <= CNT_ONE)); // R4

    AST_RESTART_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(state_q) == LEG_GAP_HI) && (state_q == LEG_GAP_LO)) ||
         (($past(state_q) == LEG_GAP_LO) && (state_q == LEG_GAP_HI)))
        |-> (cnt_q == $past(dead_cycles))); // R5

    AST_DISABLE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        disable_all |=> (state_q == LEG_IDLE)); // R7

endmodule

// File: rtl/hbg_gate_mask.sv
// Applies disable and per-switch fault masks to the sequenced commands.
module hbg_gate_mask
    import hbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEGS-1:0]  hi_cmd,
    input  logic [LEGS-1:0]  lo_cmd,
    input  logic             disable_all,
    input  logic [GATES-1:0] fault_mask,
    output logic [GATES-1:0] gate_en
);

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        always_comb begin
            gate_en[2*g]   = hi_cmd[g] && !disable_all && !fault_mask[2*g];
            gate_en[2*g+1] = lo_cmd[g] && !disable_all && !fault_mask[2*g+1];
        end

        AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_en[2*g] && gate_en[2*g+1])); // R3
    end

endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
    import hbg_pkg::*;
#(
    parameter int DT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_in,
    input  logic             dir_in,
    input  logic             dt_bypass,
    input  logic [DT_W-1:0]  dead_cycles,
    input  logic             disable_all,
    input  logic [GATES-1:0] fault_mask,
    output logic [GATES-1:0] gate_en
);

    logic [LEGS-1:0] want_hi;
    logic [LEGS-1:0] hi_cmd;
    logic [LEGS-1:0] lo_cmd;

    hbg_cmd_map u_map (
        .pwm_in  (pwm_in),
        .dir_in  (dir_in),
        .want_hi (want_hi)
    );

    for (genvar l = 0; l < LEGS; l++) begin : g_legs
        hbg_leg_fsm #(.DT_W(DT_W)) u_leg (
            .clk         (clk),
            .rst_n       (rst_n),
            .want_hi     (want_hi[l]),
            .dead_cycles (dead_cycles),
            .dt_bypass   (dt_bypass),
            .disable_all (disable_all),
            .hi_cmd      (hi_cmd[l]),
            .lo_cmd      (lo_cmd[l])
        );
    end

    hbg_gate_mask u_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .hi_cmd      (hi_cmd),
        .lo_cmd      (lo_cmd),
        .disable_all (disable_all),
        .fault_mask  (fault_mask),
        .gate_en     (gate_en)
    );

endmodule

// File: tb/hbridge_gate_seq_tb_top.sv
module hbridge_gate_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TB_DT_W = 6;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               pwm_in = 1'b0;
    logic               dir_in = 1'b0;
    logic               dt_bypass = 1'b0;
    logic [TB_DT_W-1:0] dead_cycles = 6'd4;
    logic               disable_all = 1'b0;
    logic [3:0]         fault_mask = 4'b0000;
    logic [3:0]         gate_en;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hbridge_gate_seq #(.DT_W(TB_DT_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwm_in      (pwm_in),
        .dir_in      (dir_in),
        .dt_bypass   (dt_bypass),
        .dead_cycles (dead_cycles),
        .disable_all (disable_all),
        .fault_mask  (fault_mask),
        .gate_en     (gate_en)
    );

    // Reference model: 0 off/idle, 1 gap->high, 2 gap->low, 3 high on, 4 low on
    int ms[2];
    int mc[2];

    function automatic bit leg_wants_high(int leg, bit pwm, bit dir);
        if (!pwm) return 1'b1;
        return (leg == 0) ? dir : !dir;
    endfunction

    function automatic logic [3:0] model_gates();
        logic [3:0] e;
        for (int l = 0; l < 2; l++) begin
            e[2*l]   = (ms[l] == 3) && !disable_all && !fault_mask[2*l];
            e[2*l+1] = (ms[l] == 4) && !disable_all && !fault_mask[2*l+1];
        end
        return e;
    endfunction

    always @(posedge clk) begin
        for (int l = 0; l < 2; l++) begin
            bit w;
            w = leg_wants_high(l, pwm_in, dir_in);
            if (!rst_n || disable_all) begin
                ms[l] = 0;
            end else if (ms[l] == 0) begin
                if (dt_bypass) ms[l] = w ? 3 : 4;
                else begin ms[l] = w ? 1 : 2; mc[l] = int'(dead_cycles); end
            end else if (ms[l] == 1 || ms[l] == 2) begin
                if (dt_bypass) ms[l] = w ? 3 : 4;
                else if (w != (ms[l] == 1)) begin ms[l] = w ? 1 : 2; mc[l] = int'(dead_cycles); end
                else if (mc[l] <= 1) ms[l] = (ms[l] == 1) ? 3 : 4;
                else mc[l] = mc[l] - 1;
            end else begin
                if (w != (ms[l] == 3)) begin
                    if (dt_bypass) ms[l] = w ? 3 : 4;
                    else begin ms[l] = w ? 1 : 2; mc[l] = int'(dead_cycles); end
                end
            end
        end
    end

    task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: gate_en actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_ne(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_2024));
        wait_ne(3);
        chk(gate_en, 4'b0000, "R1 gates off in reset");
        rst_n = 1'b1;
        wait_ne(4);
        chk(gate_en, 4'b0000, "R1 gap after reset");
        wait_ne(1);
        chk(gate_en, 4'b0101, "R2 brake on high sides");

        pwm_in = 1'b1; dir_in = 1'b1;
        wait_ne(1);
        chk(gate_en, 4'b0001, "R4 leg B gap starts");
        wait_ne(3);
        chk(gate_en, 4'b0001, "R4 leg B gap last cycle");
        wait_ne(1);
        chk(gate_en, 4'b1001, "R2 dir=1 diagonal");

        dir_in = 1'b0;
        wait_ne(1);
        chk(gate_en, 4'b0000, "R9 both legs in gap");
        wait_ne(1);
        dir_in = 1'b1;
        wait_ne(3);
        chk(gate_en, 4'b0000, "R5 restart extends gap");
        wait_ne(2);
        chk(gate_en, 4'b1001, "R5 drive after restarted gap");

        pwm_in = 1'b0;
        wait_ne(1);
        dead_cycles = 6'd20;
        wait_ne(3);
        chk(gate_en, 4'b0001, "R10 gap still running");
        wait_ne(1);
        chk(gate_en, 4'b0101, "R10 gap uses captured D");

        dt_bypass = 1'b1; pwm_in = 1'b1; dir_in = 1'b0;
        wait_ne(1);
        chk(gate_en, 4'b0110, "R6 bypass swap no gap");
        dir_in = 1'b1;
        wait_ne(1);
        chk(gate_en, 4'b1001, "R6 bypass swap back");

        dt_bypass = 1'b0; dead_cycles = 6'd3; disable_all = 1'b1;
        #1;
        chk(gate_en, 4'b0000, "R7 disable same cycle");
        wait_ne(2);
        chk(gate_en, 4'b0000, "R7 disable held");
        disable_all = 1'b0;
        wait_ne(3);
        chk(gate_en, 4'b0000, "R7 gap after release");
        wait_ne(1);
        chk(gate_en, 4'b1001, "R7 drive after release gap");

        fault_mask = 4'b0001;
        #1;
        chk(gate_en, 4'b1000, "R8 mask A high only");
        wait_ne(1);
        pwm_in = 1'b0;
        wait_ne(4);
        chk(gate_en, 4'b0100, "R8 sequencing continues under mask");
        fault_mask = 4'b0000;
        #1;
        chk(gate_en, 4'b0101, "R8 mask release restores");

        // Constrained random phase against the reference model
        wait_ne(1);
        for (int c = 0; c < 4000; c++) begin
            chk(gate_en, model_gates(), "R2/R4/R5/R6/R7/R8 random vs model");
            checks++;
            if ((gate_en[0] && gate_en[1]) || (gate_en[2] && gate_en[3])) begin
                failures++;
                $display("FAIL R3: shoot-through actual=%b expected=no leg with both on", gate_en);
            end
            if ($urandom % 8 == 0) pwm_in = ~pwm_in;
            if ($urandom % 8 == 0) dir_in = ~dir_in;
            if ($urandom % 16 == 0) dead_cycles = TB_DT_W'($urandom % 8);
            if ($urandom % 50 == 0) dt_bypass = ~dt_bypass;
            if (disable_all) begin
                if ($urandom % 3 == 0) disable_all = 1'b0;
            end else if ($urandom % 40 == 0) begin
                disable_all = 1'b1;
            end
            if ($urandom % 60 == 0) fault_mask[$urandom % 4] ^= 1'b1;
            wait_ne(1);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule